// File: doc/BRIEF.md
# Configuration Shadow RAM with Two-Sector Flash Loader

The block keeps a one-sector (4 KB, 2048 x 16-bit) copy of a device configuration image in an internal RAM. The image comes from an external flash at startup. The flash holds two redundant configuration sectors: the lower one at flash word 0x000 and the upper one at flash word 0x800. After reset, or on a `reload` pulse, the loader checks a signature word in each sector and copies the first valid sector word by word. When neither sector is valid, it writes a built-in default image instead. A `busy` output stays high for the whole load.

Host software reaches the configuration words through one parallel access port. A single transaction carries the start strobe, the direction, a 12-bit word address, the write data and an address-length flag. A select bit decides where the port goes. When it is 1, the access is served from the shadow RAM. When it is 0, the access is forwarded to an external serial-EEPROM engine over a request/acknowledge port. The select bit takes the value of the `strap_sel` input during reset, and software can change it later. Direct pin toggling (bit-bang) is passed through to the EEPROM pins only while the EEPROM is selected. Writes to the shadow change the RAM copy only.

The loader FSM has five states. LD_SIG0 reads the lower signature; it moves to LD_COPY when the signature is good, and to LD_SIG1 when it is bad. LD_SIG1 reads the upper signature; it moves to LD_COPY when that signature is good, and to LD_FILL when it is bad. LD_COPY copies one flash word per handshake and goes to LD_IDLE after the last word. LD_FILL writes one default word per cycle and goes to LD_IDLE after the last word. LD_IDLE goes to LD_SIG0 on `reload`, and reset also enters LD_SIG0.

The access FSM also has five states. PT_IDLE takes a start: it moves to PT_HOLD when a load is running, to PT_RAM when the shadow is selected, and to PT_EXT otherwise. PT_HOLD dispatches to PT_RAM or PT_EXT once `busy` falls. PT_RAM always moves to PT_DONE. PT_EXT moves to PT_DONE on `ee_ack`. PT_DONE always returns to PT_IDLE.

Top module: `cfgmirror_top`

## Requirements
- R1: While reset is asserted and after it, `shadow_sel` equals `strap_sel`. A cycle with `sel_wr` high loads `sel_val` into it.
- R2: From reset, and from a `reload` pulse seen while idle, `busy` is high until the whole image is written. A `reload` pulse while `busy` is high is ignored. `fl_req` is low whenever `busy` is low.
- R3: A sector is valid when bits [15:14] of its word at sector offset 0x012 equal 2'b01. When the lower sector is valid, shadow word i equals flash word i (i = 0..0x7FF).
- R4: The lower signature (flash word 0x012) is always requested first. The upper one (0x812) is requested only when the lower is invalid. When only the upper sector is valid, shadow word i equals flash word 0x800+i.
- R5: When neither sector is valid, the shadow holds 0xFFFF in every word except word 0x005 = 0x0C4A, word 0x00A = 0x0060 and word 0x012 = 0x4000.
- R6: `fl_req` and `fl_addr` stay unchanged until a cycle with `fl_rdy` high. `fl_data` is taken only in such a cycle.
- R7: With the shadow selected and no load running, `acc_done` is high for exactly one cycle, two clock edges after the edge that samples `acc_start`. For a read, `acc_rdata` then holds the addressed word. The shadow uses `acc_addr[10:0]`, and bit 11 is ignored.
- R8: A shadow write changes only the RAM copy. A later reload brings back the flash contents.
- R9: A start issued while `busy` is high is held. It completes only after `busy` falls, and `acc_done` is never high while `busy` is high.
- R10: With the EEPROM selected, an access raises `ee_req` with `ee_wr`, `ee_addr`, `ee_wdata` and `ee_alen` copied from the request. These stay stable until `ee_ack`. `acc_done` follows in the next cycle, with `acc_rdata` equal to the `ee_rdata` given with the acknowledge.
- R11: With the EEPROM selected, `bb_en` high and no access in flight, `bb_gnt` is 1. `ee_cs`, `ee_sk` and `ee_di` follow `bb_cs`, `bb_sk` and `bb_di`, and `bb_do` follows `ee_do`.
- R12: With the shadow selected, bit-bang is refused. `bb_gnt`, `bb_do`, `ee_cs`, `ee_sk` and `ee_di` stay low whatever `bb_en` is, and the shadow contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_sel | input | 1 | Reset value of the select bit (1 = shadow RAM) |
| sel_wr | input | 1 | Write strobe for the select bit |
| sel_val | input | 1 | Value written into the select bit |
| shadow_sel | output | 1 | Current select bit |
| reload | input | 1 | Pulse that starts a new load from flash |
| busy | output | 1 | High while a load runs |
| fl_req | output | 1 | Flash word read request |
| fl_addr | output | 12 | Flash word address (bit 11 picks the sector) |
| fl_rdy | input | 1 | Flash data valid, completes the request |
| fl_data | input | 16 | Flash read data |
| acc_start | input | 1 | Access start strobe |
| acc_wr | input | 1 | Access direction (1 = write) |
| acc_addr | input | 12 | Access word address |
| acc_wdata | input | 16 | Access write data |
| acc_alen | input | 1 | Explicit EEPROM address length flag |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 16 | Read data of the last access |
| ee_req | output | 1 | Request to the external EEPROM engine |
| ee_wr | output | 1 | EEPROM request direction |
| ee_addr | output | 12 | EEPROM request word address |
| ee_wdata | output | 16 | EEPROM request write data |
| ee_alen | output | 1 | EEPROM address length flag |
| ee_ack | input | 1 | EEPROM engine completion |
| ee_rdata | input | 16 | EEPROM engine read data |
| bb_en | input | 1 | Bit-bang mode request |
| bb_cs | input | 1 | Bit-bang chip select |
| bb_sk | input | 1 | Bit-bang serial clock |
| bb_di | input | 1 | Bit-bang data toward the EEPROM |
| bb_gnt | output | 1 | Bit-bang mode granted |
| bb_do | output | 1 | Bit-bang data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select pin |
| ee_sk | output | 1 | EEPROM serial clock pin |
| ee_di | output | 1 | EEPROM data-in pin |
| ee_do | input | 1 | EEPROM data-out pin |

## Verification
A loader that takes the wrong branch after a signature read shows up in two ways. The requested flash addresses come in a different order, and the shadow words read back belong to the other sector or to the default image. Both are visible as soon as `busy` falls. A wrong word index or a lost handshake corrupts scattered words, which random reads over the whole address range reveal on the next access. A select bit or access state that goes wrong is seen within a few cycles: the EEPROM port moves when it should be quiet, bit-bang pins leak through, `acc_done` appears at the wrong edge, or data comes back during a load.

// File: rtl/cfgmirror_pkg.sv
package cfgmirror_pkg;

    // Loader sequencing states
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_SIG0,
        LD_SIG1,
        LD_COPY,
        LD_FILL
    } ld_state_t;

    // Host access states
    typedef enum logic [2:0] {
        PT_IDLE,
        PT_HOLD,
        PT_RAM,
        PT_EXT,
        PT_DONE
    } pt_state_t;

    // Pattern that marks a sector as holding a usable image
    localparam logic [1:0] SIG_GOOD = 2'b01;

    // Built-in image used when no flash sector is usable
    function automatic logic [15:0] default_word(input logic [15:0] idx);
        logic [15:0] w;
        case (idx)
            16'h0005: w = 16'h0C4A;
            16'h000A: w = 16'h0060;
            16'h0012: w = 16'h4000;
            default:  w = 16'hFFFF;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cfgmirror_loader.sv
module cfgmirror_loader
    import cfgmirror_pkg::*;
#(
    parameter int DW        = 16,
    parameter int IMG_WORDS = 2048,
    parameter int SIG_IDX   = 'h12,
    localparam int IMG_AW   = $clog2(IMG_WORDS),
    localparam int FAW      = IMG_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    output logic              fl_req_o,
    output logic [FAW-1:0]    fl_addr_o,
    input  logic              fl_rdy_i,
    input  logic [DW-1:0]     fl_data_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [IMG_AW-1:0] wr_addr_o,
    output logic [DW-1:0]     wr_data_o
);

    localparam logic [IMG_AW-1:0] LAST_IDX = IMG_AW'(IMG_WORDS - 1);
    localparam logic [IMG_AW-1:0] SIG_POS  = IMG_AW'(SIG_IDX);

    ld_state_t         state, state_nxt;
    logic [IMG_AW-1:0] idx, idx_nxt;
    logic              upper, upper_nxt;
    logic              sig_ok;
    logic              at_last;

    assign sig_ok  = (fl_data_i[DW-1:DW-2] == SIG_GOOD);
    assign at_last = (idx == LAST_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_SIG0;
            idx   <= '0;
            upper <= 1'b0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
            upper <= upper_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        upper_nxt = upper;
        unique case (state)
            LD_IDLE: begin
                if (reload_i) state_nxt = LD_SIG0;
            end
            LD_SIG0: begin
                if (fl_rdy_i) begin
                    idx_nxt = '0;
                    if (sig_ok) begin
                        upper_nxt = 1'b0;
                        state_nxt = LD_COPY;
                    end else begin
                        state_nxt = LD_SIG1;
                    end
                end
            end
            LD_SIG1: begin
                if (fl_rdy_i) begin
                    idx_nxt = '0;
                    if (sig_ok) begin
                        upper_nxt = 1'b1;
                        state_nxt = LD_COPY;
                    end else begin
                        state_nxt = LD_FILL;
                    end
                end
            end
            LD_COPY: begin
                if (fl_rdy_i) begin
                    idx_nxt = idx + 1'b1;
                    if (at_last) state_nxt = LD_IDLE;
                end
            end
            LD_FILL: begin
                idx_nxt = idx + 1'b1;
                if (at_last) state_nxt = LD_IDLE;
            end
            default: state_nxt = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fl_req_o  = 1'b0;
        fl_addr_o = '0;
        wr_en_o   = 1'b0;
        wr_addr_o = idx;
        wr_data_o = fl_data_i;
        busy_o    = (state != LD_IDLE);
        unique case (state)
            LD_IDLE: ;
            LD_SIG0: begin
                fl_req_o  = 1'b1;
                fl_addr_o = {1'b0, SIG_POS};
            end
            LD_SIG1: begin
                fl_req_o  = 1'b1;
                fl_addr_o = {1'b1, SIG_POS};
            end
            LD_COPY: begin
                fl_req_o  = 1'b1;
                fl_addr_o = {upper, idx};
                wr_en_o   = fl_rdy_i;
            end
            LD_FILL: begin
                wr_en_o   = 1'b1;
                wr_data_o = DW'(default_word(16'(idx)));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgmirror_ram.sv
module cfgmirror_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Same-cycle read so the access FSM needs a single RAM state
    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/cfgmirror_port.sv
module cfgmirror_port
    import cfgmirror_pkg::*;
#(
    parameter int DW     = 16,
    parameter int HAW    = 12,
    parameter int IMG_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              sel_i,
    input  logic              acc_start_i,
    input  logic              acc_wr_i,
    input  logic [HAW-1:0]    acc_addr_i,
    input  logic [DW-1:0]     acc_wdata_i,
    input  logic              acc_alen_i,
    output logic              acc_done_o,
    output logic [DW-1:0]     acc_rdata_o,
    output logic              ram_we_o,
    output logic [IMG_AW-1:0] ram_addr_o,
    output logic [DW-1:0]     ram_wdata_o,
    input  logic [DW-1:0]     ram_rdata_i,
    output logic              ee_req_o,
    output logic              ee_wr_o,
    output logic [HAW-1:0]    ee_addr_o,
    output logic [DW-1:0]     ee_wdata_o,
    output logic              ee_alen_o,
    input  logic              ee_ack_i,
    input  logic [DW-1:0]     ee_rdata_i,
    input  logic              bb_en_i,
    input  logic [2:0]        bb_pins_i,
    output logic [2:0]        ee_pins_o,
    input  logic              ee_do_i,
    output logic              bb_do_o,
    output logic              bb_gnt_o
);

    pt_state_t      st, st_nxt;
    logic           req_wr;
    logic [HAW-1:0] req_addr;
    logic [DW-1:0]  req_wdata;
    logic           req_alen;
    logic [DW-1:0]  rd_q;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= PT_IDLE;
            req_wr    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            req_alen  <= 1'b0;
            rd_q      <= '0;
        end else begin
            st <= st_nxt;
            if (st == PT_IDLE && acc_start_i) begin
                req_wr    <= acc_wr_i;
                req_addr  <= acc_addr_i;
                req_wdata <= acc_wdata_i;
                req_alen  <= acc_alen_i;
            end
            if (st == PT_RAM) rd_q <= ram_rdata_i;
            if (st == PT_EXT && ee_ack_i) rd_q <= ee_rdata_i;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            PT_IDLE: begin
                if (acc_start_i) begin
                    if (busy_i)     st_nxt = PT_HOLD;
                    else if (sel_i) st_nxt = PT_RAM;
                    else            st_nxt = PT_EXT;
                end
            end
            PT_HOLD: begin
                if (!busy_i) st_nxt = sel_i ? PT_RAM : PT_EXT;
            end
            PT_RAM:  st_nxt = PT_DONE;
            PT_EXT:  if (ee_ack_i) st_nxt = PT_DONE;
            PT_DONE: st_nxt = PT_IDLE;
            default: st_nxt = PT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_done_o  = (st == PT_DONE);
        acc_rdata_o = rd_q;
        ram_we_o    = (st == PT_RAM) && req_wr;
        ram_addr_o  = req_addr[IMG_AW-1:0];
        ram_wdata_o = req_wdata;
        ee_req_o    = (st == PT_EXT);
        ee_wr_o     = req_wr;
        ee_addr_o   = req_addr;
        ee_wdata_o  = req_wdata;
        ee_alen_o   = req_alen;
        bb_gnt_o    = !sel_i && bb_en_i && (st == PT_IDLE);
        bb_do_o     = bb_gnt_o && ee_do_i;
    end

    // Pin steering, one lane per bit-bang pin
    for (genvar p = 0; p < 3; p++) begin : g_pin
        assign ee_pins_o[p] = bb_gnt_o && bb_pins_i[p];
    end

endmodule

// File: rtl/cfgmirror_top.sv
module cfgmirror_top
    import cfgmirror_pkg::*;
#(
    parameter int DW        = 16,
    parameter int IMG_WORDS = 2048,
    parameter int HAW       = 12,
    parameter int SIG_IDX   = 'h12,
    localparam int IMG_AW   = $clog2(IMG_WORDS),
    localparam int FAW      = IMG_AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_sel,
    input  logic           sel_wr,
    input  logic           sel_val,
    output logic           shadow_sel,
    input  logic           reload,
    output logic           busy,
    output logic           fl_req,
    output logic [FAW-1:0] fl_addr,
    input  logic           fl_rdy,
    input  logic [DW-1:0]  fl_data,
    input  logic           acc_start,
    input  logic           acc_wr,
    input  logic [HAW-1:0] acc_addr,
    input  logic [DW-1:0]  acc_wdata,
    input  logic           acc_alen,
    output logic           acc_done,
    output logic [DW-1:0]  acc_rdata,
    output logic           ee_req,
    output logic           ee_wr,
    output logic [HAW-1:0] ee_addr,
    output logic [DW-1:0]  ee_wdata,
    output logic           ee_alen,
    input  logic           ee_ack,
    input  logic [DW-1:0]  ee_rdata,
    input  logic           bb_en,
    input  logic           bb_cs,
    input  logic           bb_sk,
    input  logic           bb_di,
    output logic           bb_gnt,
    output logic           bb_do,
    output logic           ee_cs,
    output logic           ee_sk,
    output logic           ee_di,
    input  logic           ee_do
);

    logic              sel_q;
    logic              ld_we;
    logic [IMG_AW-1:0] ld_waddr;
    logic [DW-1:0]     ld_wdata;
    logic              pt_we;
    logic [IMG_AW-1:0] pt_addr;
    logic [DW-1:0]     pt_wdata;
    logic [DW-1:0]     ram_q;
    logic              ram_we;
    logic [IMG_AW-1:0] ram_waddr;
    logic [DW-1:0]     ram_wdata;
    logic [2:0]        pins_out;

    // Select bit: strap value while in reset, software write afterwards
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= strap_sel;
        else if (sel_wr) sel_q <= sel_val;
    end
    assign shadow_sel = sel_q;

    cfgmirror_loader #(
        .DW(DW), .IMG_WORDS(IMG_WORDS), .SIG_IDX(SIG_IDX)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .reload_i(reload),
        .fl_req_o(fl_req), .fl_addr_o(fl_addr),
        .fl_rdy_i(fl_rdy), .fl_data_i(fl_data),
        .busy_o(busy),
        .wr_en_o(ld_we), .wr_addr_o(ld_waddr), .wr_data_o(ld_wdata)
    );

    // Loader owns the write port while it runs
    assign ram_we    = ld_we | pt_we;
    assign ram_waddr = ld_we ? ld_waddr : pt_addr;
    assign ram_wdata = ld_we ? ld_wdata : pt_wdata;

    cfgmirror_ram #(.DW(DW), .DEPTH(IMG_WORDS)) u_ram (
        .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
        .raddr_i(pt_addr), .rdata_o(ram_q)
    );

    cfgmirror_port #(.DW(DW), .HAW(HAW), .IMG_AW(IMG_AW)) u_port (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .sel_i(sel_q),
        .acc_start_i(acc_start), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
        .acc_wdata_i(acc_wdata), .acc_alen_i(acc_alen),
        .acc_done_o(acc_done), .acc_rdata_o(acc_rdata),
        .ram_we_o(pt_we), .ram_addr_o(pt_addr), .ram_wdata_o(pt_wdata),
        .ram_rdata_i(ram_q),
        .ee_req_o(ee_req), .ee_wr_o(ee_wr), .ee_addr_o(ee_addr),
        .ee_wdata_o(ee_wdata), .ee_alen_o(ee_alen),
        .ee_ack_i(ee_ack), .ee_rdata_i(ee_rdata),
        .bb_en_i(bb_en), .bb_pins_i({bb_di, bb_sk, bb_cs}),
        .ee_pins_o(pins_out), .ee_do_i(ee_do),
        .bb_do_o(bb_do), .bb_gnt_o(bb_gnt)
    );

    assign ee_cs = pins_out[0];
    assign ee_sk = pins_out[1];
    assign ee_di = pins_out[2];

endmodule

// File: rtl/cfgmirror_chk.sv
module cfgmirror_chk #(
    parameter int FAW = 12,
    parameter int HAW = 12,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           fl_req,
    input logic [FAW-1:0] fl_addr,
    input logic           fl_rdy,
    input logic           acc_done,
    input logic           shadow_sel,
    input logic           bb_gnt,
    input logic           bb_do,
    input logic           ee_cs,
    input logic           ee_sk,
    input logic           ee_di,
    input logic           ee_req,
    input logic           ee_ack,
    input logic [HAW-1:0] ee_addr,
    input logic [DW-1:0]  ee_wdata
);

    p_idle_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_req);

    p_flash_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_rdy) |=> (fl_req && $stable(fl_addr)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> !busy);

    p_ee_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_wdata)));

    p_bb_refused_r12: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_sel |-> (!bb_gnt && !bb_do && !ee_cs && !ee_sk && !ee_di));

endmodule

bind cfgmirror_top cfgmirror_chk #(.FAW(FAW), .HAW(HAW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fl_req(fl_req),
    .fl_addr(fl_addr), .fl_rdy(fl_rdy), .acc_done(acc_done),
    .shadow_sel(shadow_sel), .bb_gnt(bb_gnt), .bb_do(bb_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_req(ee_req), .ee_ack(ee_ack), .ee_addr(ee_addr), .ee_wdata(ee_wdata)
);

// File: tb/sim_cfgmirror_top.sv
module sim_cfgmirror_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strap_sel, sel_wr, sel_val, shadow_sel;
    logic        reload, busy;
    logic        fl_req, fl_rdy;
    logic [11:0] fl_addr;
    logic [15:0] fl_data;
    logic        acc_start, acc_wr, acc_alen, acc_done;
    logic [11:0] acc_addr;
    logic [15:0] acc_wdata, acc_rdata;
    logic        ee_req, ee_wr, ee_alen, ee_ack;
    logic [11:0] ee_addr;
    logic [15:0] ee_wdata, ee_rdata;
    logic        bb_en, bb_cs, bb_sk, bb_di, bb_gnt, bb_do;
    logic        ee_cs, ee_sk, ee_di, ee_do;

    int n_chk  = 0;
    int n_fail = 0;

    int          fl_mode = 0;
    int          fl_wait = 0;
    int          nlog    = 0;
    logic [11:0] alog [4];
    int          ee_wait = 0;
    logic [11:0] ee_last_addr;
    logic [15:0] ee_last_wdata;
    logic        ee_last_wr, ee_last_alen;
    logic        busy_at_done;
    logic [15:0] model [2048];

    always #4 clk = ~clk;

    cfgmirror_top u0 (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .sel_wr(sel_wr),
        .sel_val(sel_val), .shadow_sel(shadow_sel), .reload(reload), .busy(busy),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdy(fl_rdy), .fl_data(fl_data),
        .acc_start(acc_start), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_alen(acc_alen), .acc_done(acc_done),
        .acc_rdata(acc_rdata), .ee_req(ee_req), .ee_wr(ee_wr), .ee_addr(ee_addr),
        .ee_wdata(ee_wdata), .ee_alen(ee_alen), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .bb_en(bb_en), .bb_cs(bb_cs), .bb_sk(bb_sk), .bb_di(bb_di),
        .bb_gnt(bb_gnt), .bb_do(bb_do), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    // Flash contents for each scenario
    function automatic logic [15:0] fw(input int mode, input logic [11:0] a);
        logic [15:0] h;
        h = 16'((32'(a) * 32'd40503 + 32'(mode) * 32'd7919) ^ 32'h5A5A);
        if (a == 12'h012) begin
            if (mode == 0)      h = 16'h4ABC;
            else if (mode == 1) h = 16'hC000;
            else                h = 16'h0123;
        end
        if (a == 12'h812) begin
            if (mode == 0)      h = 16'h7111;
            else if (mode == 1) h = 16'h5AA5;
            else                h = 16'hBEEF;
        end
        return h;
    endfunction

    // Expected shadow image after a load in the given scenario
    function automatic logic [15:0] exp_word(input int mode, input logic [10:0] i);
        if (mode == 0) return fw(0, {1'b0, i});
        if (mode == 1) return fw(1, {1'b1, i});
        if (i == 11'h005) return 16'h0C4A;
        if (i == 11'h00A) return 16'h0060;
        if (i == 11'h012) return 16'h4000;
        return 16'hFFFF;
    endfunction

    function automatic logic [15:0] ew(input logic [11:0] a);
        return 16'(32'(a) * 32'd3 + 32'h1234);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // Flash responder with random latency
    initial begin
        fl_rdy = 1'b0;
        fl_data = '0;
        forever begin
            @(negedge clk);
            if (fl_req) begin
                if (fl_wait == 0) begin
                    fl_rdy  = 1'b1;
                    fl_data = fw(fl_mode, fl_addr);
                    if (nlog < 4) alog[nlog] = fl_addr;
                    nlog++;
                    fl_wait = int'($urandom % 3);
                end else begin
                    fl_rdy = 1'b0;
                    fl_wait--;
                end
            end else begin
                fl_rdy = 1'b0;
            end
        end
    end

    // EEPROM engine responder
    initial begin
        ee_ack = 1'b0;
        ee_rdata = '0;
        forever begin
            @(negedge clk);
            if (ee_req && !ee_ack) begin
                if (ee_wait == 0) begin
                    ee_ack        = 1'b1;
                    ee_rdata      = ew(ee_addr);
                    ee_last_addr  = ee_addr;
                    ee_last_wdata = ee_wdata;
                    ee_last_wr    = ee_wr;
                    ee_last_alen  = ee_alen;
                    ee_wait       = int'($urandom % 4);
                end else begin
                    ee_wait--;
                end
            end else begin
                ee_ack = 1'b0;
            end
        end
    end

    task automatic acc(input bit wr, input logic [11:0] a, input logic [15:0] d,
                       input bit al, output logic [15:0] rd, output int lat);
        @(negedge clk);
        acc_start = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; acc_alen = al;
        @(negedge clk);
        acc_start = 1'b0;
        lat = 1;
        while (!acc_done && lat < 30000) begin
            @(negedge clk);
            lat++;
        end
        rd = acc_rdata;
        busy_at_done = busy;
        @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " load finishes"}, 32'(busy), 32'd0);
    endtask

    task automatic pulse_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    task automatic load_model(input int mode);
        for (int i = 0; i < 2048; i++) model[i] = exp_word(mode, 11'(i));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          lat;
        logic [11:0] a;
        logic [15:0] d;
        void'($urandom(32'd4242));
        rst_n = 1'b0; strap_sel = 1'b1; sel_wr = 1'b0; sel_val = 1'b0; reload = 1'b0;
        acc_start = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0; acc_alen = 1'b0;
        bb_en = 1'b0; bb_cs = 1'b0; bb_sk = 1'b0; bb_di = 1'b0; ee_do = 1'b0;
        fl_mode = 0;
        repeat (3) @(negedge clk);
        chk("R1 select follows strap in reset", 32'(shadow_sel), 32'd1);
        chk("R2 busy in reset", 32'(busy), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 select after reset", 32'(shadow_sel), 32'd1);
        wait_idle("R2 reset");
        chk("R4 lower signature requested first", 32'(alog[0]), 32'h012);
        chk("R2 no flash request when idle", 32'(fl_req), 32'd0);
        load_model(0);

        // Exact latency and bit 11 ignored
        acc(1'b0, 12'h012, 16'h0, 1'b0, rd, lat);
        chk("R7 done latency", 32'(lat), 32'd2);
        chk("R3 signature word copied", 32'(rd), 32'(fw(0, 12'h012)));
        acc(1'b0, 12'h8A3, 16'h0, 1'b0, rd, lat);
        chk("R7 address bit 11 ignored", 32'(rd), 32'(fw(0, 12'h0A3)));
        acc(1'b0, 12'h7FF, 16'h0, 1'b0, rd, lat);
        chk("R3 last word copied", 32'(rd), 32'(fw(0, 12'h7FF)));

        // Random mixed reads and writes against the model
        for (int i = 0; i < 150; i++) begin
            a = 12'($urandom);
            d = 16'($urandom);
            if ($urandom % 3 == 0) begin
                acc(1'b1, a, d, 1'b0, rd, lat);
                model[a[10:0]] = d;
            end else begin
                acc(1'b0, a, 16'h0, 1'b0, rd, lat);
                chk("R3 R8 random shadow access", 32'(rd), 32'(model[a[10:0]]));
            end
        end

        // Overwrite then reload restores the flash copy
        acc(1'b1, 12'h123, 16'h0F0F, 1'b0, rd, lat);
        acc(1'b0, 12'h123, 16'h0, 1'b0, rd, lat);
        chk("R8 write lands in shadow", 32'(rd), 32'h0F0F);
        pulse_reload();
        wait_idle("R8 reload");
        acc(1'b0, 12'h123, 16'h0, 1'b0, rd, lat);
        chk("R8 reload restores flash word", 32'(rd), 32'(fw(0, 12'h123)));

        // Only upper sector valid, access issued during the load
        fl_mode = 1; nlog = 0;
        pulse_reload();
        acc(1'b0, 12'h005, 16'h0, 1'b0, rd, lat);
        chk("R9 held access waits for load", 32'(lat > 100), 32'd1);
        chk("R9 busy low at done", 32'(busy_at_done), 32'd0);
        chk("R9 held read data", 32'(rd), 32'(fw(1, 12'h805)));
        chk("R4 lower checked first", 32'(alog[0]), 32'h012);
        chk("R4 upper checked second", 32'(alog[1]), 32'h812);
        for (int i = 0; i < 40; i++) begin
            a = 12'($urandom);
            acc(1'b0, a, 16'h0, 1'b0, rd, lat);
            chk("R4 upper sector image", 32'(rd), 32'(exp_word(1, a[10:0])));
        end

        // Neither sector valid, second reload while busy is ignored
        fl_mode = 2; nlog = 0;
        pulse_reload();
        repeat (20) @(negedge clk);
        pulse_reload();
        wait_idle("R5 fill");
        repeat (10) @(negedge clk);
        chk("R2 reload while busy ignored", 32'(busy), 32'd0);
        chk("R2 only one signature pair read", 32'(nlog), 32'd2);
        acc(1'b0, 12'h005, 16'h0, 1'b0, rd, lat);
        chk("R5 default word 0x005", 32'(rd), 32'h0C4A);
        acc(1'b0, 12'h00A, 16'h0, 1'b0, rd, lat);
        chk("R5 default word 0x00A", 32'(rd), 32'h0060);
        acc(1'b0, 12'h012, 16'h0, 1'b0, rd, lat);
        chk("R5 default word 0x012", 32'(rd), 32'h4000);
        for (int i = 0; i < 20; i++) begin
            a = 12'($urandom);
            acc(1'b0, a, 16'h0, 1'b0, rd, lat);
            chk("R5 default image", 32'(rd), 32'(exp_word(2, a[10:0])));
        end

        // Bit-bang refused with shadow selected
        bb_en = 1'b1; bb_cs = 1'b1; bb_sk = 1'b1; bb_di = 1'b1; ee_do = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 grant refused", 32'(bb_gnt), 32'd0);
        chk("R12 pins quiet", 32'({ee_cs, ee_sk, ee_di, bb_do}), 32'd0);
        bb_en = 1'b0;
        acc(1'b0, 12'h00A, 16'h0, 1'b0, rd, lat);
        chk("R12 shadow untouched", 32'(rd), 32'h0060);

        // Switch to EEPROM
        @(negedge clk); sel_wr = 1'b1; sel_val = 1'b0;
        @(negedge clk); sel_wr = 1'b0;
        chk("R1 select written", 32'(shadow_sel), 32'd0);
        bb_en = 1'b1; bb_cs = 1'b1; bb_sk = 1'b0; bb_di = 1'b1; ee_do = 1'b0;
        @(negedge clk);
        chk("R11 grant", 32'(bb_gnt), 32'd1);
        chk("R11 pins follow pattern A", 32'({ee_cs, ee_sk, ee_di, bb_do}), 32'b1010);
        bb_cs = 1'b0; bb_sk = 1'b1; bb_di = 1'b0; ee_do = 1'b1;
        @(negedge clk);
        chk("R11 pins follow pattern B", 32'({ee_cs, ee_sk, ee_di, bb_do}), 32'b0101);
        bb_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            logic al;
            logic w;
            a  = 12'($urandom);
            d  = 16'($urandom);
            al = 1'($urandom);
            w  = 1'($urandom);
            acc(w, a, d, al, rd, lat);
            chk("R10 forwarded address", 32'(ee_last_addr), 32'(a));
            chk("R10 forwarded direction and length", 32'({ee_last_wr, ee_last_alen}), 32'({w, al}));
            if (w) chk("R10 forwarded write data", 32'(ee_last_wdata), 32'(d));
            else   chk("R10 returned read data", 32'(rd), 32'(ew(a)));
        end
        chk("R10 no request left open", 32'(ee_req), 32'd0);

        // Back to shadow: EEPROM traffic did not touch it
        @(negedge clk); sel_wr = 1'b1; sel_val = 1'b1;
        @(negedge clk); sel_wr = 1'b0;
        acc(1'b0, 12'h005, 16'h0, 1'b0, rd, lat);
        chk("R10 shadow kept during EEPROM mode", 32'(rd), 32'h0C4A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule